// File: doc/BRIEF.md
# Soft power wake-event latch with off-delay timer

This block watches four wake sources on the always-on side of a system: two serial receive lines, an active-low ring indicator and an active-low push button. Every source passes through a two-flop synchronizer and a falling-edge detector. Each detected edge sets a sticky bit in a status register. A host reads that register over a small register bus, and the read returns the bits and clears them. The ring and receive-line bits, each gated by a mask register, combine into a power-on request. The button bit is recorded, but it never raises that request.

The block also holds a programmable power-off delay. When both off-control bits are set, a button press starts a timer that counts pulses of an external slow tick (nominally 10 ms). After (N+1) half-second steps the timer emits a one-cycle done pulse. Before the first tick is counted one extra tick is absorbed, so the delay is never shorter than nominal and at most one tick longer. A further press while the timer runs restarts it.

Top module: `softPowerLatch`

## Requirements
- R1: A falling edge on `rxdA` sets status bit 0 and a falling edge on `rxdB` sets status bit 1 (status at address 0). Rising edges set nothing.
- R2: A falling edge on `ringN` sets status bit 3.
- R3: A falling edge on `btnN` sets status bit 2, and that bit never asserts `powerOnReq`.
- R4: A bus read of address 0 returns the latched bits and clears all of them. Bits 7:4 always read 0.
- R5: An edge detected in the same cycle as a clearing read of address 0 leaves its bit set after the read.
- R6: `powerOnReq` is high while any of status bits 0, 1 or 3 is set with its mask bit set. The mask is at address 3, only bits 0, 1 and 3 are stored, and it resets to 0x0B.
- R7: Address 1 holds the 6-bit delay code N in bits 5:0. It resets to 0, and bits 7:6 read 0.
- R8: With control bits 0 (off enable) and 1 (off-delay select) at address 2 both set, a button press starts the timer (`offBusy` high). After exactly (N+1)*TICKS_PER_STEP+1 counted `tickIn` pulses, `offDone` is high for one cycle and `offBusy` falls. With either control bit clear, a press starts nothing.
- R9: A button press while the timer runs reloads the full interval.
- R10: Clearing either control bit while the timer runs stops it with no done pulse.
- R11: After reset the status is 0, the control register is 0, and `powerOnReq`, `offBusy` and `offDone` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rxdA | input | 1 | First serial receive line, asynchronous |
| rxdB | input | 1 | Second serial receive line, asynchronous |
| ringN | input | 1 | Ring indicator, active low, asynchronous |
| btnN | input | 1 | Power button, active low, asynchronous |
| tickIn | input | 1 | One-cycle slow tick pulse, synchronous to clk |
| busSel | input | 1 | Register bus select |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data of the addressed register (combinational) |
| powerOnReq | output | 1 | Power-on request from masked wake bits |
| offDone | output | 1 | One-cycle pulse when the off-delay expires |
| offBusy | output | 1 | Off-delay timer running |

## Verification
The hardest case to reach is an edge that becomes visible in exactly the cycle in which a clearing read is sampled. The synchronizer and edge detector put three clock edges between the pin and the latch. The bench therefore changes a receive line at a falling clock edge, lets two rising edges pass, and then issues the read so that it spans the third. The timer restart case needs a second press to land partway through a running interval. The bench checks that the done pulse then arrives a full interval after the second press, not at the end of the first interval.

// File: rtl/softPwrPkg.sv
package softPwrPkg;
  localparam int NUM_SRC = 4;
  localparam int IDX_RXA = 0;
  localparam int IDX_RXB = 1;
  localparam int IDX_BTN = 2;
  localparam int IDX_RING = 3;
  localparam logic [NUM_SRC-1:0] WAKE_BITS = 4'b1011;

  localparam logic [1:0] ADDR_STATUS = 2'd0;
  localparam logic [1:0] ADDR_DELAY  = 2'd1;
  localparam logic [1:0] ADDR_CTRL   = 2'd2;
  localparam logic [1:0] ADDR_MASK   = 2'd3;

  typedef struct packed {
    logic clrStatus;
    logic wrDelay;
    logic wrCtrl;
    logic wrMask;
    logic loadTimer;
    logic cancelTimer;
  } ctlStrb_t;
endpackage

// File: rtl/wakeEdgeSync.sv
module wakeEdgeSync #(
  parameter int NUM_IN = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] pinsIn,
  output logic [NUM_IN-1:0] fallEdge
);
  for (genvar g = 0; g < NUM_IN; g++) begin : gSync
    logic s1, s2, prevQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
        prevQ <= 1'b1;
      end else begin
        s1 <= pinsIn[g];
        s2 <= s1;
        prevQ <= s2;
      end
    end
    assign fallEdge[g] = prevQ & ~s2;
  end
endmodule

// File: rtl/wakeCtl.sv
module wakeCtl
  import softPwrPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busRd,
  input  logic       busWr,
  input  logic [1:0] busAddr,
  input  logic       btnEdge,
  input  logic       offEn,
  input  logic       offSel,
  input  logic       offBusy,
  output ctlStrb_t   strb
);
  logic rdAct, wrAct, armed;

  assign rdAct = busSel & busRd;
  assign wrAct = busSel & busWr;
  assign armed = offEn & offSel;

  always_comb begin
    strb = '0;
    strb.clrStatus   = rdAct && (busAddr == ADDR_STATUS);
    strb.wrDelay     = wrAct && (busAddr == ADDR_DELAY);
    strb.wrCtrl      = wrAct && (busAddr == ADDR_CTRL);
    strb.wrMask      = wrAct && (busAddr == ADDR_MASK);
    strb.loadTimer   = btnEdge && armed;
    strb.cancelTimer = offBusy && !armed;
  end

  AST_CANCEL_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (offBusy && !(offEn && offSel)) |=> !offBusy); // R10
endmodule

// File: rtl/wakeDatapath.sv
module wakeDatapath
  import softPwrPkg::*;
#(
  parameter int TICKS_PER_STEP = 50,
  parameter int DLY_W = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrb_t           strb,
  input  logic [1:0]         busAddr,
  input  logic [7:0]         busWdata,
  input  logic [NUM_SRC-1:0] fallEdge,
  input  logic               tickIn,
  output logic [7:0]         busRdata,
  output logic               powerOnReq,
  output logic               offDone,
  output logic               offBusy,
  output logic               offEn,
  output logic               offSel
);
  localparam int CNT_MAX = (2 ** DLY_W) * TICKS_PER_STEP + 1;
  localparam int CNT_W = $clog2(CNT_MAX + 1);

  logic [NUM_SRC-1:0] evtQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [DLY_W-1:0]   delayQ;
  logic [1:0]         ctrlQ;
  logic [CNT_W-1:0]   cntQ;
  logic [CNT_W-1:0]   loadVal;
  logic               busyQ, doneQ;

  // status latches: a clearing read never hides a fresh edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtQ <= '0;
    else       evtQ <= (strb.clrStatus ? '0 : evtQ) | fallEdge;
  end

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ  <= WAKE_BITS;
      delayQ <= '0;
      ctrlQ  <= '0;
    end else begin
      if (strb.wrMask)  maskQ  <= busWdata[NUM_SRC-1:0] & WAKE_BITS;
      if (strb.wrDelay) delayQ <= busWdata[DLY_W-1:0];
      if (strb.wrCtrl)  ctrlQ  <= busWdata[1:0];
    end
  end

  assign offEn  = ctrlQ[0];
  assign offSel = ctrlQ[1];
  assign powerOnReq = |(evtQ & maskQ & WAKE_BITS);

  // one extra tick absorbs the unknown phase of the first tick
  assign loadVal = CNT_W'((int'(delayQ) + 1) * TICKS_PER_STEP + 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ  <= '0;
      busyQ <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (strb.cancelTimer) begin
        busyQ <= 1'b0;
        cntQ  <= '0;
      end else if (strb.loadTimer) begin
        busyQ <= 1'b1;
        cntQ  <= loadVal;
      end else if (busyQ && tickIn) begin
        if (cntQ == CNT_W'(1)) begin
          busyQ <= 1'b0;
          doneQ <= 1'b1;
          cntQ  <= '0;
        end else begin
          cntQ <= cntQ - CNT_W'(1);
        end
      end
    end
  end

  assign offBusy = busyQ;
  assign offDone = doneQ;

  always_comb begin
    unique case (busAddr)
      ADDR_STATUS: busRdata = {{(8-NUM_SRC){1'b0}}, evtQ};
      ADDR_DELAY:  busRdata = {{(8-DLY_W){1'b0}}, delayQ};
      ADDR_CTRL:   busRdata = {6'b0, ctrlQ};
      default:     busRdata = {{(8-NUM_SRC){1'b0}}, maskQ};
    endcase
  end

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrStatus && fallEdge == '0) |=> evtQ == '0); // R4
  AST_EVENT_NOT_LOST: assert property (@(posedge clk) disable iff (!rstN)
    (fallEdge != '0) |=> ((evtQ & $past(fallEdge)) == $past(fallEdge))); // R5
  AST_BTN_NO_POWER: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerOnReq) |-> ((evtQ & WAKE_BITS) != '0)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    offDone |=> !offDone); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    int'(cntQ) <= CNT_MAX); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    offDone |-> !offBusy); // R8
endmodule

// File: rtl/softPowerLatch.sv
module softPowerLatch
  import softPwrPkg::*;
#(
  parameter int TICKS_PER_STEP = 50,
  parameter int DLY_W = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxdA,
  input  logic       rxdB,
  input  logic       ringN,
  input  logic       btnN,
  input  logic       tickIn,
  input  logic       busSel,
  input  logic       busRd,
  input  logic       busWr,
  input  logic [1:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       powerOnReq,
  output logic       offDone,
  output logic       offBusy
);
  logic [NUM_SRC-1:0] pins, fallEdge;
  ctlStrb_t strb;
  logic offEn, offSel;

  assign pins = {ringN, btnN, rxdB, rxdA};

  wakeEdgeSync #(.NUM_IN(NUM_SRC)) uSync (
    .clk(clk), .rstN(rstN), .pinsIn(pins), .fallEdge(fallEdge));

  wakeCtl uCtl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busRd(busRd), .busWr(busWr),
    .busAddr(busAddr), .btnEdge(fallEdge[IDX_BTN]), .offEn(offEn),
    .offSel(offSel), .offBusy(offBusy), .strb(strb));

  wakeDatapath #(.TICKS_PER_STEP(TICKS_PER_STEP), .DLY_W(DLY_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .busWdata(busWdata), .fallEdge(fallEdge), .tickIn(tickIn),
    .busRdata(busRdata), .powerOnReq(powerOnReq), .offDone(offDone),
    .offBusy(offBusy), .offEn(offEn), .offSel(offSel));
endmodule

// File: tb/softPowerLatch_test.sv
module softPowerLatch_test;
  localparam int TPS = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxdA = 1'b1, rxdB = 1'b1, ringN = 1'b1, btnN = 1'b1, tickIn = 1'b0;
  logic busSel = 1'b0, busRd = 1'b0, busWr = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic powerOnReq, offDone, offBusy;

  int checkCount = 0;
  int failCount = 0;
  int doneCount = 0;

  always #10 clk = ~clk;

  softPowerLatch #(.TICKS_PER_STEP(TPS)) uut (
    .clk(clk), .rstN(rstN), .rxdA(rxdA), .rxdB(rxdB), .ringN(ringN),
    .btnN(btnN), .tickIn(tickIn), .busSel(busSel), .busRd(busRd),
    .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .powerOnReq(powerOnReq), .offDone(offDone),
    .offBusy(offBusy));

  always @(posedge clk) if (offDone) doneCount++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busRd = 1'b1; busAddr = a;
    #1 d = busRdata;
    @(negedge clk);
    busSel = 1'b0; busRd = 1'b0;
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic pulseTick();
    @(negedge clk); tickIn = 1'b1;
    @(negedge clk); tickIn = 1'b0;
  endtask

  task automatic pressBtn();
    @(negedge clk); btnN = 1'b0;
    waitCyc(5);
  endtask

  task automatic releaseBtn();
    @(negedge clk); btnN = 1'b1;
    waitCyc(5);
  endtask

  task automatic testReset();
    logic [7:0] d;
    chk("R11 powerOnReq", powerOnReq, 0);
    chk("R11 offBusy", offBusy, 0);
    chk("R11 offDone", offDone, 0);
    busRead(2'd0, d); chk("R11 status", d, 8'h00);
    busRead(2'd2, d); chk("R11 ctrl", d, 8'h00);
    busRead(2'd1, d); chk("R7 delay reset", d, 8'h00);
    busRead(2'd3, d); chk("R6 mask reset", d, 8'h0B);
  endtask

  task automatic testRxd();
    logic [7:0] d;
    @(negedge clk); rxdA = 1'b0; waitCyc(5);
    chk("R6 powerOnReq rxdA", powerOnReq, 1);
    busRead(2'd0, d); chk("R1 rxdA bit0", d, 8'h01);
    busRead(2'd0, d); chk("R4 cleared", d, 8'h00);
    chk("R4 powerOnReq after clear", powerOnReq, 0);
    @(negedge clk); rxdA = 1'b1; waitCyc(5);
    busRead(2'd0, d); chk("R1 rising ignored", d, 8'h00);
    @(negedge clk); rxdB = 1'b0; waitCyc(5);
    busRead(2'd0, d); chk("R1 rxdB bit1", d, 8'h02);
    @(negedge clk); rxdB = 1'b1; waitCyc(5);
  endtask

  task automatic testRing();
    logic [7:0] d;
    @(negedge clk); ringN = 1'b0; waitCyc(5);
    chk("R2 powerOnReq ring", powerOnReq, 1);
    busRead(2'd0, d); chk("R2 ring bit3", d, 8'h08);
    @(negedge clk); ringN = 1'b1; waitCyc(5);
  endtask

  task automatic testButton();
    logic [7:0] d;
    pressBtn();
    chk("R3 button no power", powerOnReq, 0);
    busRead(2'd0, d); chk("R3 button bit2", d, 8'h04);
    releaseBtn();
  endtask

  task automatic testMask();
    logic [7:0] d;
    busWrite(2'd3, 8'h00);
    @(negedge clk); rxdA = 1'b0; waitCyc(5);
    chk("R6 masked off", powerOnReq, 0);
    busRead(2'd0, d); chk("R6 still latched", d, 8'h01);
    @(negedge clk); rxdA = 1'b1;
    busWrite(2'd3, 8'hFF);
    busRead(2'd3, d); chk("R6 mask stored bits", d, 8'h0B);
    @(negedge clk); ringN = 1'b0; waitCyc(5);
    chk("R6 ring enabled", powerOnReq, 1);
    busRead(2'd0, d);
    @(negedge clk); ringN = 1'b1; waitCyc(5);
  endtask

  task automatic testDelayReg();
    logic [7:0] d;
    busWrite(2'd1, 8'hFF);
    busRead(2'd1, d); chk("R7 delay field", d, 8'h3F);
    busWrite(2'd1, 8'h00);
  endtask

  task automatic testCollide();
    logic [7:0] d;
    @(negedge clk); rxdB = 1'b0;
    @(posedge clk); @(posedge clk);
    busRead(2'd0, d); chk("R5 read before latch", d, 8'h00);
    busRead(2'd0, d); chk("R5 event kept", d, 8'h02);
    @(negedge clk); rxdB = 1'b1; waitCyc(5);
  endtask

  task automatic runTimer(input logic [5:0] code, string req);
    logic [7:0] d;
    int n, base;
    n = (int'(code) + 1) * TPS + 1;
    busWrite(2'd1, {2'b00, code});
    busWrite(2'd2, 8'h03);
    base = doneCount;
    pressBtn();
    chk({req, " busy"}, offBusy, 1);
    for (int i = 0; i < n - 1; i++) pulseTick();
    chk({req, " no early done"}, doneCount - base, 0);
    pulseTick();
    chk({req, " done pulse"}, offDone, 1);
    @(negedge clk);
    chk({req, " one cycle"}, offDone, 0);
    chk({req, " busy fell"}, offBusy, 0);
    releaseBtn();
    busRead(2'd0, d);
  endtask

  task automatic testRestart();
    logic [7:0] d;
    int base;
    busWrite(2'd1, 8'h01);
    busWrite(2'd2, 8'h03);
    base = doneCount;
    pressBtn();
    for (int i = 0; i < 3; i++) pulseTick();
    releaseBtn();
    pressBtn();
    for (int i = 0; i < 4; i++) pulseTick();
    chk("R9 restarted no done", doneCount - base, 0);
    chk("R9 still busy", offBusy, 1);
    pulseTick();
    chk("R9 done after full interval", offDone, 1);
    releaseBtn();
    busRead(2'd0, d);
  endtask

  task automatic testNoStart();
    logic [7:0] d;
    int base;
    busWrite(2'd1, 8'h00);
    busWrite(2'd2, 8'h01);
    base = doneCount;
    pressBtn();
    chk("R8 no start busy", offBusy, 0);
    for (int i = 0; i < 6; i++) pulseTick();
    chk("R8 no start done", doneCount - base, 0);
    releaseBtn();
    busRead(2'd0, d);
  endtask

  task automatic testCancel();
    logic [7:0] d;
    int base;
    busWrite(2'd2, 8'h03);
    base = doneCount;
    pressBtn();
    chk("R10 started", offBusy, 1);
    pulseTick();
    busWrite(2'd2, 8'h02);
    @(negedge clk);
    chk("R10 busy cleared", offBusy, 0);
    for (int i = 0; i < 6; i++) pulseTick();
    chk("R10 no done", doneCount - base, 0);
    releaseBtn();
    busRead(2'd0, d);
  endtask

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);
    testReset();
    testRxd();
    testRing();
    testButton();
    testMask();
    testDelayReg();
    testCollide();
    runTimer(6'd0, "R8 code0");
    runTimer(6'd2, "R8 code2");
    testRestart();
    testNoStart();
    testCancel();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end

  initial begin
    #3000000;
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  end
endmodule